// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator with GPIO Folding

This block gathers interrupt requests from many sources into three status words and reduces them to one level-sensitive interrupt line for the processor. The first and second status words are 16 bits wide. The third word is 32 bits wide and collects general-purpose pin interrupts. Each word has a mask of the same width. The pin word is first reduced through its mask to a single summary bit. That bit appears in the first status word, at a fixed position. The processor line is then the masked OR of the first and second words.

Each source drives its request through one of several identical event ports. An event port carries a valid strobe, a 6-bit source number and a level flag: 1 sets the bit, 0 clears it. Software reaches the three masks and the three status words through a small register bus. A read returns data in the same cycle. A write takes effect at the next clock edge. Software can write the masks but cannot write the status words. A synchronous active-low reset clears every register.

Top module: `irq_fold_top`

## Requirements
- R1: After reset, all three status words and all three masks read as zero, and `cpu_irq` is low.
- R2: An event with source number 0..15 sets (level 1) or clears (level 0) the bit of that number in the first status word. The change is visible through the bus read of address 0 after the next clock edge.
- R3: An event with source number 16..31 sets or clears bit (number − 16) of the second status word, which is read at address 2.
- R4: An event with source number 32..63 sets or clears bit (number − 32) of the pin status word, which is read at address 4.
- R5: Bit 8 of the first status word reads 1 exactly when (pin status AND pin mask) is nonzero. An event with source number 8 has no effect on this bit.
- R6: `cpu_irq` is a registered level. It goes high one clock edge after (first status AND first mask) OR (second status AND second mask) becomes nonzero, and it goes low one clock edge after that value becomes zero. Mask writes and status changes both count.
- R7: The masks are read and written at address 1 (first word), address 3 (second word) and address 5 (pin word). The 16-bit masks keep only write-data bits 15:0 and read back zero above bit 15. Addresses 6 and 7 read zero.
- R8: A bus write to a status address (0, 2 or 4) changes no register.
- R9: If one port asserts and another port deasserts the same source bit in the same cycle, the bit ends up set. This holds whichever port carries the assert.
- R10: A status word does not change in a cycle in which no valid event falls in its range of source numbers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_vld | input | SRC_PORTS (2) | Valid strobe, one per event port |
| src_idx | input | SRC_PORTS*IDX_W (12) | Source number for each port; port p occupies bits p*IDX_W upward |
| src_lvl | input | SRC_PORTS (2) | 1 = set the bit, 0 = clear the bit, one per port |
| bus_addr | input | 3 | Register address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | DATA_W (32) | Write data |
| bus_rd_data | output | DATA_W (32) | Read data for `bus_addr`, same cycle |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
The bench uses the default parameters: two event ports, widths of 16, 16 and 32 bits, and the summary bit at position 8. With two ports, an assert and a deassert of the same bit can arrive in the same cycle in both port orders, which is what R9 needs. The widths let the bench reach the top bit of the pin word (source number 63), an index that collides with the summary position (source number 8), and the two-edge path from a source event to `cpu_irq`. Mask writes with bits set above bit 15 show that the narrow masks truncate the written value.

// File: rtl/irq_fold_pkg.sv
// Package: irq_fold_pkg
// Holds the register address map shared by the register file and the bench-visible bus.
// Assumes a 3-bit register address; unused addresses read as zero.
package irq_fold_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_L1_STAT = 3'd0,
        A_L1_MASK = 3'd1,
        A_L2_STAT = 3'd2,
        A_L2_MASK = 3'd3,
        A_GP_STAT = 3'd4,
        A_GP_MASK = 3'd5
    } reg_addr_e;

endpackage

// File: rtl/irq_status_bank.sv
// Module: irq_status_bank
// Level status register covering the source numbers BASE .. BASE+W-1.
// Every event port is decoded in parallel. A set from any port beats a clear
// from any other port that targets the same bit. An optional hole bit is never
// stored, so a neighbour can place its own summary bit at that position.
// Assumes each src_idx value is IDX_W bits wide and BASE+W fits in the
// source-number space.
module irq_status_bank #(
    parameter int W        = 16,
    parameter int BASE     = 0,
    parameter int PORTS    = 2,
    parameter int IDX_W    = 6,
    parameter int HOLE_EN  = 0,
    parameter int HOLE_BIT = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PORTS-1:0]       src_vld,
    input  logic [PORTS*IDX_W-1:0] src_idx,
    input  logic [PORTS-1:0]       src_lvl,
    output logic [W-1:0]           stat_q
);

    localparam int OFF_W = (W > 1) ? $clog2(W) : 1;

    logic [IDX_W-1:0] idx_a [PORTS];
    logic [OFF_W-1:0] off_a [PORTS];
    logic [PORTS-1:0] hit_a;
    logic [W-1:0]     set_vec;
    logic [W-1:0]     clr_vec;
    logic [W-1:0]     stat_nxt;

    // Per port: slice out the source number, check the range, form the bit offset
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign idx_a[p] = src_idx[p*IDX_W +: IDX_W];
        assign hit_a[p] = (int'(idx_a[p]) >= BASE) && (int'(idx_a[p]) < BASE + W);
        assign off_a[p] = OFF_W'(int'(idx_a[p]) - BASE);
    end

    // Gather set and clear requests from all ports
    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int p = 0; p < PORTS; p++) begin
            if (src_vld[p] && hit_a[p]) begin
                if (src_lvl[p]) set_vec[off_a[p]] = 1'b1;
                else            clr_vec[off_a[p]] = 1'b1;
            end
        end
    end

    // Next state: clear first, then set so that an assert wins; the hole stays zero
    always_comb begin
        stat_nxt = (stat_q & ~clr_vec) | set_vec;
        if (HOLE_EN != 0) stat_nxt[HOLE_BIT] = 1'b0;
    end

    // Status storage
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_nxt;
    end

    // Assertions: a set event lands, and the word holds when no event targets it
    for (genvar p = 0; p < PORTS; p++) begin : g_chk
        AST_ASSERT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (src_vld[p] && src_lvl[p] && hit_a[p] &&
             !((HOLE_EN != 0) && (int'(off_a[p]) == HOLE_BIT)))
            |=> stat_q[$past(off_a[p])]); // R9
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(src_vld & hit_a)) |=> $stable(stat_q)); // R10

endmodule

// File: rtl/irq_fold_regs.sv
// Module: irq_fold_regs
// Mask storage and register-bus read mux. The masks can be written; the status
// words are read-only, so writes to their addresses are dropped. Reads are
// combinational. Assumes DATA_W is at least as wide as the widest word.
module irq_fold_regs
    import irq_fold_pkg::*;
#(
    parameter int L1_W   = 16,
    parameter int L2_W   = 16,
    parameter int GP_W   = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wr_data,
    input  logic [L1_W-1:0]   l1_view,
    input  logic [L2_W-1:0]   l2_stat,
    input  logic [GP_W-1:0]   gp_stat,
    output logic [L1_W-1:0]   l1_mask,
    output logic [L2_W-1:0]   l2_mask,
    output logic [GP_W-1:0]   gp_mask,
    output logic [DATA_W-1:0] bus_rd_data
);

    reg_addr_e addr_e;
    assign addr_e = reg_addr_e'(bus_addr);

    // Mask writes; writes to status addresses fall through unused
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l1_mask <= '0;
            l2_mask <= '0;
            gp_mask <= '0;
        end else if (bus_wr_en) begin
            case (addr_e)
                A_L1_MASK: l1_mask <= bus_wr_data[L1_W-1:0];
                A_L2_MASK: l2_mask <= bus_wr_data[L2_W-1:0];
                A_GP_MASK: gp_mask <= bus_wr_data[GP_W-1:0];
                default:   ;
            endcase
        end
    end

    // Read mux, zero-extended to the bus width
    always_comb begin
        case (addr_e)
            A_L1_STAT: bus_rd_data = DATA_W'(l1_view);
            A_L1_MASK: bus_rd_data = DATA_W'(l1_mask);
            A_L2_STAT: bus_rd_data = DATA_W'(l2_stat);
            A_L2_MASK: bus_rd_data = DATA_W'(l2_mask);
            A_GP_STAT: bus_rd_data = DATA_W'(gp_stat);
            A_GP_MASK: bus_rd_data = DATA_W'(gp_mask);
            default:   bus_rd_data = '0;
        endcase
    end

    AST_L1_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && addr_e == A_L1_MASK) |=> l1_mask == $past(bus_wr_data[L1_W-1:0])); // R7

    AST_GP_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && addr_e == A_GP_MASK) |=> gp_mask == $past(bus_wr_data[GP_W-1:0])); // R7

    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_en |=> ($stable(l1_mask) && $stable(l2_mask) && $stable(gp_mask))); // R8

endmodule

// File: rtl/irq_fold_out.sv
// Module: irq_fold_out
// Final masked OR of the first and second status words, registered into the
// processor interrupt line. Assumes l1_view already carries the pin summary bit.
module irq_fold_out #(
    parameter int L1_W = 16,
    parameter int L2_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [L1_W-1:0] l1_view,
    input  logic [L1_W-1:0] l1_mask,
    input  logic [L2_W-1:0] l2_stat,
    input  logic [L2_W-1:0] l2_mask,
    output logic            cpu_irq
);

    logic l1_any;
    logic l2_any;

    assign l1_any = |(l1_view & l1_mask);
    assign l2_any = |(l2_stat & l2_mask);

    // Register the combined request level
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_irq <= 1'b0;
        else        cpu_irq <= l1_any | l2_any;
    end

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(l1_view & l1_mask)) || (|(l2_stat & l2_mask))) |=> cpu_irq); // R6

    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|(l1_view & l1_mask)) && !(|(l2_stat & l2_mask))) |=> !cpu_irq); // R6

endmodule

// File: rtl/irq_fold_top.sv
// Module: irq_fold_top
// Two-level interrupt aggregator. Three status banks share the event ports. The
// pin bank is masked and reduced to one summary bit, which takes position
// SUM_BIT in the first word. The first and second words are masked and ORed
// into a registered processor interrupt.
// Assumes SUM_BIT < L1_W and DATA_W >= every word width.
module irq_fold_top
    import irq_fold_pkg::*;
#(
    parameter int SRC_PORTS = 2,
    parameter int L1_W      = 16,
    parameter int L2_W      = 16,
    parameter int GP_W      = 32,
    parameter int SUM_BIT   = 8,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = $clog2(L1_W + L2_W + GP_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SRC_PORTS-1:0]       src_vld,
    input  logic [SRC_PORTS*IDX_W-1:0] src_idx,
    input  logic [SRC_PORTS-1:0]       src_lvl,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr_en,
    input  logic [DATA_W-1:0]          bus_wr_data,
    output logic [DATA_W-1:0]          bus_rd_data,
    output logic                       cpu_irq
);

    localparam int L2_BASE = L1_W;
    localparam int GP_BASE = L1_W + L2_W;

    logic [L1_W-1:0] l1_raw;
    logic [L1_W-1:0] l1_view;
    logic [L2_W-1:0] l2_stat;
    logic [GP_W-1:0] gp_stat;
    logic [L1_W-1:0] l1_mask;
    logic [L2_W-1:0] l2_mask;
    logic [GP_W-1:0] gp_mask;
    logic            gp_sum;

    // First word; the summary position is never stored here
    irq_status_bank #(
        .W(L1_W), .BASE(0), .PORTS(SRC_PORTS), .IDX_W(IDX_W),
        .HOLE_EN(1), .HOLE_BIT(SUM_BIT)
    ) u_l1 (
        .clk(clk), .rst_n(rst_n), .src_vld(src_vld), .src_idx(src_idx),
        .src_lvl(src_lvl), .stat_q(l1_raw)
    );

    // Second word
    irq_status_bank #(
        .W(L2_W), .BASE(L2_BASE), .PORTS(SRC_PORTS), .IDX_W(IDX_W),
        .HOLE_EN(0), .HOLE_BIT(0)
    ) u_l2 (
        .clk(clk), .rst_n(rst_n), .src_vld(src_vld), .src_idx(src_idx),
        .src_lvl(src_lvl), .stat_q(l2_stat)
    );

    // Pin interrupt word
    irq_status_bank #(
        .W(GP_W), .BASE(GP_BASE), .PORTS(SRC_PORTS), .IDX_W(IDX_W),
        .HOLE_EN(0), .HOLE_BIT(0)
    ) u_gp (
        .clk(clk), .rst_n(rst_n), .src_vld(src_vld), .src_idx(src_idx),
        .src_lvl(src_lvl), .stat_q(gp_stat)
    );

    // Fold the masked pin word into the summary position of the first word
    always_comb begin
        gp_sum           = |(gp_stat & gp_mask);
        l1_view          = l1_raw;
        l1_view[SUM_BIT] = gp_sum;
    end

    irq_fold_regs #(
        .L1_W(L1_W), .L2_W(L2_W), .GP_W(GP_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wr_data(bus_wr_data), .l1_view(l1_view), .l2_stat(l2_stat),
        .gp_stat(gp_stat), .l1_mask(l1_mask), .l2_mask(l2_mask),
        .gp_mask(gp_mask), .bus_rd_data(bus_rd_data)
    );

    irq_fold_out #(
        .L1_W(L1_W), .L2_W(L2_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .l1_view(l1_view), .l1_mask(l1_mask),
        .l2_stat(l2_stat), .l2_mask(l2_mask), .cpu_irq(cpu_irq)
    );

    AST_SUMMARY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_L1_STAT) |-> (bus_rd_data[SUM_BIT] == (|(gp_stat & gp_mask)))); // R5

endmodule

// File: tb/irq_fold_top_test.sv
`timescale 1ns/1ps
module irq_fold_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_vld = '0;
    logic [11:0] src_idx = '0;
    logic [1:0]  src_lvl = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wr_data = '0;
    logic [31:0] bus_rd_data;
    logic        cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_fold_top uut (
        .clk(clk), .rst_n(rst_n), .src_vld(src_vld), .src_idx(src_idx),
        .src_lvl(src_lvl), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data), .cpu_irq(cpu_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rd_data;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic fire(input int port, input logic [5:0] idx, input logic lvl);
        @(negedge clk);
        src_vld[port] = 1'b1;
        src_idx[port*6 +: 6] = idx;
        src_lvl[port] = lvl;
        @(negedge clk);
        src_vld = '0;
    endtask

    task automatic fire2(input logic [5:0] i0, input logic l0, input logic [5:0] i1, input logic l1);
        @(negedge clk);
        src_vld = 2'b11;
        src_idx = {i1, i0};
        src_lvl = {l1, l0};
        @(negedge clk);
        src_vld = '0;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 8; a++) rd_check(3'(a), 32'h0, "R1 register zero after reset");
        check("R1 cpu_irq low after reset", 32'(cpu_irq), 32'h0);
    endtask

    task automatic t_level1;
        fire(0, 6'd3, 1'b1);
        rd_check(3'd0, 32'h0000_0008, "R2 set bit 3");
        fire(1, 6'd15, 1'b1);
        rd_check(3'd0, 32'h0000_8008, "R2 set bit 15");
        fire(0, 6'd3, 1'b0);
        fire(0, 6'd15, 1'b0);
        rd_check(3'd0, 32'h0, "R2 clear bits");
    endtask

    task automatic t_level2;
        fire(1, 6'd21, 1'b1);
        rd_check(3'd2, 32'h0000_0020, "R3 second word bit 5");
        rd_check(3'd0, 32'h0, "R10 first word untouched by second-word event");
        fire(0, 6'd21, 1'b0);
        rd_check(3'd2, 32'h0, "R3 clear bit 5");
    endtask

    task automatic t_gpio;
        fire(0, 6'd63, 1'b1);
        rd_check(3'd4, 32'h8000_0000, "R4 pin word bit 31");
        rd_check(3'd0, 32'h0, "R5 summary low while pin mask zero");
        wr(3'd5, 32'h8000_0000);
        rd_check(3'd0, 32'h0000_0100, "R5 summary high with pin mask");
        fire(0, 6'd8, 1'b0);
        rd_check(3'd0, 32'h0000_0100, "R5 source 8 deassert ignored");
        wr(3'd5, 32'h0);
        rd_check(3'd0, 32'h0, "R5 summary drops with mask");
        fire(1, 6'd8, 1'b1);
        rd_check(3'd0, 32'h0, "R5 source 8 assert ignored");
        fire(0, 6'd63, 1'b0);
        rd_check(3'd4, 32'h0, "R4 clear bit 31");
    endtask

    task automatic t_irq;
        wr(3'd1, 32'h0000_0008);
        fire(0, 6'd3, 1'b1);
        check("R6 cpu_irq not yet high one edge after event", 32'(cpu_irq), 32'h0);
        @(negedge clk);
        check("R6 cpu_irq high two edges after event", 32'(cpu_irq), 32'h1);
        wr(3'd1, 32'h0);
        check("R6 cpu_irq still high right after mask write", 32'(cpu_irq), 32'h1);
        @(negedge clk);
        check("R6 cpu_irq low after mask cleared", 32'(cpu_irq), 32'h0);
        fire(0, 6'd3, 1'b0);
        fire(1, 6'd16, 1'b1);
        wr(3'd3, 32'h0000_0001);
        @(negedge clk);
        check("R6 cpu_irq via second word", 32'(cpu_irq), 32'h1);
        fire(1, 6'd16, 1'b0);
        @(negedge clk);
        check("R6 cpu_irq low after second word cleared", 32'(cpu_irq), 32'h0);
        wr(3'd3, 32'h0);
        wr(3'd1, 32'h0000_0100);
        wr(3'd5, 32'h0000_0001);
        fire(0, 6'd32, 1'b1);
        @(negedge clk);
        check("R6 cpu_irq via pin summary", 32'(cpu_irq), 32'h1);
        fire(0, 6'd32, 1'b0);
        @(negedge clk);
        check("R6 cpu_irq low after pin cleared", 32'(cpu_irq), 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd5, 32'h0);
    endtask

    task automatic t_mask_rw;
        wr(3'd1, 32'hFFFF_ABCD);
        rd_check(3'd1, 32'h0000_ABCD, "R7 first mask truncated");
        wr(3'd3, 32'h1234_5678);
        rd_check(3'd3, 32'h0000_5678, "R7 second mask truncated");
        wr(3'd5, 32'hDEAD_BEEF);
        rd_check(3'd5, 32'hDEAD_BEEF, "R7 pin mask full width");
        rd_check(3'd6, 32'h0, "R7 address 6 reads zero");
        rd_check(3'd7, 32'h0, "R7 address 7 reads zero");
        wr(3'd1, 32'h0); wr(3'd3, 32'h0); wr(3'd5, 32'h0);
        rd_check(3'd1, 32'h0, "R7 first mask cleared");
    endtask

    task automatic t_status_ro;
        fire(0, 6'd2, 1'b1);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd4, 32'hFFFF_FFFF);
        rd_check(3'd0, 32'h0000_0004, "R8 first status unchanged by write");
        rd_check(3'd2, 32'h0, "R8 second status unchanged by write");
        rd_check(3'd4, 32'h0, "R8 pin status unchanged by write");
        rd_check(3'd1, 32'h0, "R8 first mask unchanged by status write");
        @(negedge clk);
        check("R8 cpu_irq stays low", 32'(cpu_irq), 32'h0);
        fire(0, 6'd2, 1'b0);
    endtask

    task automatic t_collision;
        fire2(6'd40, 1'b0, 6'd40, 1'b1);
        rd_check(3'd4, 32'h0000_0100, "R9 assert on port 1 wins");
        fire(0, 6'd40, 1'b0);
        fire2(6'd5, 1'b1, 6'd5, 1'b0);
        rd_check(3'd0, 32'h0000_0020, "R9 assert on port 0 wins");
        fire2(6'd5, 1'b0, 6'd6, 1'b1);
        rd_check(3'd0, 32'h0000_0040, "R9 independent bits on both ports");
        fire(0, 6'd6, 1'b0);
    endtask

    task automatic t_hold;
        fire(0, 6'd1, 1'b1);
        fire(1, 6'd17, 1'b1);
        repeat (5) @(negedge clk);
        rd_check(3'd0, 32'h0000_0002, "R10 first word holds while idle");
        rd_check(3'd2, 32'h0000_0002, "R10 second word holds while idle");
        fire(0, 6'd50, 1'b1);
        rd_check(3'd0, 32'h0000_0002, "R10 first word ignores pin event");
        rd_check(3'd4, 32'h0004_0000, "R4 pin bit 18 set");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level1();
        t_level2();
        t_gpio();
        t_irq();
        t_mask_rw();
        t_status_ro();
        t_collision();
        t_hold();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule